// File: doc/BRIEF.md
# Dual-Byte Receive Symbol Status Encoder

This block sits directly after a pair of 8b/10b decoders on a two-byte-wide receive path. On every clock it takes one decoded byte and one control-character flag from each lane. It also takes a code-violation flag and a running-disparity flag from each decoder, plus overflow and underflow indications from the elastic buffer. It produces a 16-bit receive data word, one K flag per byte, and one 3-bit status code, all in the style of a PHY receive interface.

Any byte that could not be decoded is replaced with a fixed control symbol, K30.7 (0xFE), and its K flag is set. The status code is then chosen by a strict priority, so the consumer sees a single summary per word. Under that priority, a decode error on either byte hides a disparity error on the other byte of the same word. A byte with only a disparity error is passed through as the decoder produced it. All outputs are registered together with exactly one cycle of latency.

Top module: `rxstat_encoder`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are data 0, K flags 0 and status 000b.
- R2: Data, K flags and status for the inputs sampled at one edge appear together after that edge and stay unchanged until the next edge. There is no combinational path from inputs to outputs.
- R3: A byte whose lane flags a decode error is output as 0xFE (bits [8i+7:8i] for lane i, lane 0 in the low byte), and that lane's K flag is 1.
- R4: A byte whose lane flags no decode error is output with its data and K flag unchanged, whatever its disparity flag says.
- R5: If any lane flags a decode error, the status is 100b, regardless of disparity, overflow or underflow inputs.
- R6: A disparity error on one lane is not reported when the other lane of the same word has a decode error. The status is 100b, not 111b.
- R7: With no decode error and at least one disparity error, the status is 111b.
- R8: With no decode or disparity error and underflow asserted, the status is 110b, even if overflow is also asserted.
- R9: With no decode, disparity or underflow indication and overflow asserted, the status is 101b.
- R10: With no error indication at all, the status is 000b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_byte_i | input | 16 | Decoded bytes, lane 0 in bits [7:0] |
| dec_k_i | input | 2 | Control-character flag per lane |
| code_err_i | input | 2 | Decode (code violation) error per lane |
| disp_err_i | input | 2 | Running-disparity error per lane |
| eb_over_i | input | 1 | Elastic buffer overflow indication |
| eb_under_i | input | 1 | Elastic buffer underflow indication |
| rx_data_o | output | 16 | Registered receive data word |
| rx_k_o | output | 2 | Registered K flag per byte |
| rx_status_o | output | 3 | Registered receive status code |

## Verification
The hardest situation to reach is a word in which one lane has a decode error and the other lane has only a disparity error. Elastic-buffer flags are active at the same time, so every rank of the priority is contending at once. Both the masking of the disparity error and the untouched pass-through of the disparity-only byte must hold in that word. Directed vectors set up this combination in both lane orders. The random phase draws each error flag independently with a moderate probability, so mixed words recur many times with varied byte data and K flags.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;

  typedef enum logic [2:0] {
    RXS_OK     = 3'b000,
    RXS_DECODE = 3'b100,
    RXS_OVER   = 3'b101,
    RXS_UNDER  = 3'b110,
    RXS_DISP   = 3'b111
  } rx_status_e;

  localparam int STATUS_W = 3;

endpackage

// File: rtl/rxstat_lane_fix.sv
// Per-lane substitution: an undecodable byte becomes the fixed control symbol.
module rxstat_lane_fix #(
  parameter int          BYTE_W  = 8,
  parameter logic [BYTE_W-1:0] SUB_VAL = 8'hFE
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              k_i,
  input  logic              code_err_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              k_o
);

  always_comb begin
    if (code_err_i) begin
      byte_o = SUB_VAL;
      k_o    = 1'b1;
    end else begin
      byte_o = byte_i;
      k_o    = k_i;
    end
  end

endmodule

// File: rtl/rxstat_prio.sv
// Strict priority: decode > disparity > underflow > overflow > normal.
module rxstat_prio
  import rxstat_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0]    code_err_i,
  input  logic [LANES-1:0]    disp_err_i,
  input  logic                eb_under_i,
  input  logic                eb_over_i,
  output logic [STATUS_W-1:0] status_o
);

  rx_status_e sel;

  always_comb begin
    if (|code_err_i)      sel = RXS_DECODE;
    else if (|disp_err_i) sel = RXS_DISP;
    else if (eb_under_i)  sel = RXS_UNDER;
    else if (eb_over_i)   sel = RXS_OVER;
    else                  sel = RXS_OK;
    status_o = sel;
  end

endmodule

// File: rtl/rxstat_encoder.sv
module rxstat_encoder
  import rxstat_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SUB_VAL = 8'hFE,
  localparam int DATA_W = LANES * BYTE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   dec_byte_i,
  input  logic [LANES-1:0]    dec_k_i,
  input  logic [LANES-1:0]    code_err_i,
  input  logic [LANES-1:0]    disp_err_i,
  input  logic                eb_over_i,
  input  logic                eb_under_i,
  output logic [DATA_W-1:0]   rx_data_o,
  output logic [LANES-1:0]    rx_k_o,
  output logic [STATUS_W-1:0] rx_status_o
);

  logic [DATA_W-1:0]   data_nx;
  logic [LANES-1:0]    k_nx;
  logic [STATUS_W-1:0] status_nx;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rxstat_lane_fix #(
      .BYTE_W (BYTE_W),
      .SUB_VAL(SUB_VAL)
    ) u_fix (
      .byte_i    (dec_byte_i[g*BYTE_W +: BYTE_W]),
      .k_i       (dec_k_i[g]),
      .code_err_i(code_err_i[g]),
      .byte_o    (data_nx[g*BYTE_W +: BYTE_W]),
      .k_o       (k_nx[g])
    );
  end

  rxstat_prio #(.LANES(LANES)) u_prio (
    .code_err_i(code_err_i),
    .disp_err_i(disp_err_i),
    .eb_under_i(eb_under_i),
    .eb_over_i (eb_over_i),
    .status_o  (status_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data_o   <= '0;
      rx_k_o      <= '0;
      rx_status_o <= RXS_OK;
    end else begin
      rx_data_o   <= data_nx;
      rx_k_o      <= k_nx;
      rx_status_o <= status_nx;
    end
  end

endmodule

module rxstat_encoder_chk #(
  parameter int LANES  = 2,
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] SUB_VAL = 8'hFE
) (
  input logic                      clk,
  input logic                      rst,
  input logic [LANES*BYTE_W-1:0]   dec_byte_i,
  input logic [LANES-1:0]          dec_k_i,
  input logic [LANES-1:0]          code_err_i,
  input logic [LANES-1:0]          disp_err_i,
  input logic                      eb_over_i,
  input logic                      eb_under_i,
  input logic [LANES*BYTE_W-1:0]   rx_data_o,
  input logic [LANES-1:0]          rx_k_o,
  input logic [2:0]                rx_status_o
);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (rx_data_o == '0 && rx_k_o == '0 && rx_status_o == 3'b000));

  p_decode_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (|code_err_i) |=> rx_status_o == 3'b100);

  p_disp_masked_r6: assert property (@(posedge clk) disable iff (rst)
    ((|code_err_i) && (|disp_err_i)) |=> rx_status_o != 3'b111);

  p_disp_r7: assert property (@(posedge clk) disable iff (rst)
    (!(|code_err_i) && (|disp_err_i)) |=> rx_status_o == 3'b111);

  p_under_r8: assert property (@(posedge clk) disable iff (rst)
    (!(|code_err_i) && !(|disp_err_i) && eb_under_i) |=> rx_status_o == 3'b110);

  p_over_r9: assert property (@(posedge clk) disable iff (rst)
    (!(|code_err_i) && !(|disp_err_i) && !eb_under_i && eb_over_i)
      |=> rx_status_o == 3'b101);

  p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (!(|code_err_i) && !(|disp_err_i) && !eb_under_i && !eb_over_i)
      |=> rx_status_o == 3'b000);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    p_sub_r3: assert property (@(posedge clk) disable iff (rst)
      code_err_i[g] |=> (rx_data_o[g*BYTE_W +: BYTE_W] == SUB_VAL && rx_k_o[g]));

    p_pass_r4: assert property (@(posedge clk) disable iff (rst)
      !code_err_i[g] |=> (rx_data_o[g*BYTE_W +: BYTE_W] == $past(dec_byte_i[g*BYTE_W +: BYTE_W])
                          && rx_k_o[g] == $past(dec_k_i[g])));
  end

endmodule

bind rxstat_encoder rxstat_encoder_chk #(
  .LANES  (LANES),
  .BYTE_W (BYTE_W),
  .SUB_VAL(SUB_VAL)
) u_chk (.*);

// File: tb/rxstat_encoder_test.sv
module rxstat_encoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] dec_byte_i = '0;
  logic [1:0]  dec_k_i = '0;
  logic [1:0]  code_err_i = '0;
  logic [1:0]  disp_err_i = '0;
  logic        eb_over_i = 1'b0;
  logic        eb_under_i = 1'b0;
  logic [15:0] rx_data_o;
  logic [1:0]  rx_k_o;
  logic [2:0]  rx_status_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] prev_data = '0;
  logic [1:0]  prev_k = '0;
  logic [2:0]  prev_stat = '0;

  always #2.5 clk = ~clk;

  rxstat_encoder uut (
    .clk(clk), .rst(rst), .dec_byte_i(dec_byte_i), .dec_k_i(dec_k_i),
    .code_err_i(code_err_i), .disp_err_i(disp_err_i),
    .eb_over_i(eb_over_i), .eb_under_i(eb_under_i),
    .rx_data_o(rx_data_o), .rx_k_o(rx_k_o), .rx_status_o(rx_status_o)
  );

  function automatic logic [2:0] exp_status(logic [1:0] ce, logic [1:0] de,
                                            logic un, logic ov);
    if (ce != 0)      return 3'b100;
    else if (de != 0) return 3'b111;
    else if (un)      return 3'b110;
    else if (ov)      return 3'b101;
    return 3'b000;
  endfunction

  function automatic logic [15:0] exp_data(logic [15:0] d, logic [1:0] ce);
    logic [15:0] r = d;
    if (ce[0]) r[7:0]  = 8'hFE;
    if (ce[1]) r[15:8] = 8'hFE;
    return r;
  endfunction

  function automatic logic [1:0] exp_k(logic [1:0] k, logic [1:0] ce);
    return k | ce;
  endfunction

  function automatic string req_of(logic [1:0] ce, logic [1:0] de,
                                   logic un, logic ov);
    if (ce != 0 && de != 0) return "R6";
    if (ce != 0)            return "R5";
    if (de != 0)            return "R7";
    if (un)                 return "R8";
    if (ov)                 return "R9";
    return "R10";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] d, logic [1:0] k, logic [1:0] ce,
                       logic [1:0] de, logic un, logic ov);
    logic [15:0] ed;
    logic [1:0]  ek;
    logic [2:0]  es;
    @(negedge clk);
    dec_byte_i = d; dec_k_i = k; code_err_i = ce; disp_err_i = de;
    eb_under_i = un; eb_over_i = ov;
    #1;
    // R2: new inputs must not reach the outputs before the edge
    check("R2", {13'd0, rx_k_o, rx_data_o, rx_status_o},
                {13'd0, prev_k, prev_data, prev_stat});
    @(posedge clk);
    #1;
    ed = exp_data(d, ce);
    ek = exp_k(k, ce);
    es = exp_status(ce, de, un, ov);
    // R3 substitution, R4 pass-through
    check((ce != 0) ? "R3" : "R4", {14'd0, rx_k_o, rx_data_o}, {14'd0, ek, ed});
    check(req_of(ce, de, un, ov), {29'd0, rx_status_o}, {29'd0, es});
    prev_data = ed; prev_k = ek; prev_stat = es;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1F2E3D4C);
    dec_byte_i = 16'hA5C3; code_err_i = 2'b11; disp_err_i = 2'b11;
    eb_over_i = 1'b1; eb_under_i = 1'b1; dec_k_i = 2'b11;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {13'd0, rx_k_o, rx_data_o, rx_status_o}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    dec_byte_i = '0; dec_k_i = '0; code_err_i = '0; disp_err_i = '0;
    eb_over_i = 1'b0; eb_under_i = 1'b0;
    @(posedge clk);
    #1;
    prev_data = '0; prev_k = '0; prev_stat = '0;

    // Directed corner cases
    apply(16'h1234, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0); // R10
    apply(16'h1234, 2'b00, 2'b01, 2'b00, 1'b0, 1'b0); // R3 lane 0, R5
    apply(16'h1234, 2'b01, 2'b10, 2'b00, 1'b0, 1'b0); // R3 lane 1
    apply(16'h5A7C, 2'b00, 2'b01, 2'b10, 1'b1, 1'b1); // R6, R4 disp-only lane 1
    apply(16'h5A7C, 2'b01, 2'b10, 2'b01, 1'b1, 1'b0); // R6 other order
    apply(16'h00FF, 2'b10, 2'b00, 2'b01, 1'b1, 1'b1); // R7, R4 unchanged
    apply(16'hBEEF, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1); // R8 both flags
    apply(16'hBEEF, 2'b00, 2'b00, 2'b00, 1'b1, 1'b0); // R8
    apply(16'hCAFE, 2'b11, 2'b00, 2'b00, 1'b0, 1'b1); // R9
    apply(16'hFEFE, 2'b00, 2'b11, 2'b11, 1'b1, 1'b1); // R5 both lanes
    apply(16'h0000, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0); // R10

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] ce, de;
      ce[0] = ($urandom % 6) == 0;
      ce[1] = ($urandom % 6) == 0;
      de[0] = ($urandom % 5) == 0;
      de[1] = ($urandom % 5) == 0;
      apply(16'($urandom), 2'($urandom), ce, de,
            ($urandom % 4) == 0, ($urandom % 4) == 0);
    end

    // R1: reset mid-stream clears outputs
    @(negedge clk);
    rst = 1'b1;
    dec_byte_i = 16'h7777; code_err_i = 2'b01;
    @(posedge clk);
    #1;
    check("R1", {13'd0, rx_k_o, rx_data_o, rx_status_o}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule